// File: doc/BRIEF.md
# Reloadable Seconds Watchdog

This block is a watchdog timer with a resolution of one second, programmed through a single 32-bit control word. Software loads a timeout, sets the enable bit and pulses the reload strobe. A prescaler driven by the system clock produces the one-second tick. If the countdown is not reloaded before it reaches zero, the block drives a platform reset request for a fixed number of cycles. It then records, in a sticky status flag, whether survivability mode was selected at that moment.

The timeout field holds the period minus one. A field value of N therefore gives N+1 seconds, and the 10-bit field covers 1 to 1024 seconds. Software normally uses the range 70 to 1024.

A lock bit freezes the configuration until power-on reset. Reload strobes and status clears keep working while the lock is set. The status flags and the lock are cleared only by the power-on reset, so a handler that runs after a watchdog reset can still read the cause.

Top module: `reload_wdt`

## Requirements
- R1: After power-on reset (`rst_n` low), `rd_data` reads 0 and `rst_req` is low.
- R2: `rd_data` has the following layout. Bits 9:0 are the timeout field. Bit 12 is lock, bit 13 is survivability mode, bit 14 is enable and bit 15 is force. Bit 24 is expiry status without survivability and bit 25 is expiry status with survivability. Bit 31 is the reload strobe, which always reads 0. All other bits read 0.
- R3: A write that is accepted with bit 31 set and enable set restarts the countdown. `rst_req` rises exactly (N+1)·TICK_CYCLES clock cycles after the write edge, where N is the value of the timeout field.
- R4: A write with bit 31 set has no effect unless enable is 1 after that write. In that case no countdown starts and `rst_req` stays low.
- R5: A single write may set enable, force and survivability, load a new timeout and pulse reload all at once. The countdown then uses the newly written timeout.
- R6: A reload issued during a countdown restarts both the second count and the prescaler. The full period is measured from that reload.
- R7: Clearing enable stops the countdown. No reset request follows, even when enable is set again later without a reload.
- R8: On expiry, `rst_req` stays high for exactly PULSE_CYCLES cycles. When the pulse ends, bit 25 is set if survivability mode is 1, otherwise bit 24 is set. The timer then stays halted until the next reload.
- R9: Writing 1 to bit 24 or bit 25 clears that status flag. Writing 0 to them leaves them unchanged.
- R10: Once lock is set, writes to the timeout, enable, force and survivability bits are ignored, and lock itself cannot be written back to 0. Reload strobes and status clears still take effect.
- R11: Lock and the status flags are unaffected by the block's own reset request. Only `rst_n` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Value written to the control word |
| rd_data | output | 32 | Current control word (reload bit reads 0) |
| rst_req | output | 1 | Platform reset request pulse |

## Verification
The bench builds the block with TICK_CYCLES = 4 and PULSE_CYCLES = 3. With these values even a 72-second period expires within a few hundred cycles, so the exact expiry cycle and the pulse length can be counted directly. Several full expiries fit in one run: with and without survivability, and under lock. A reload that lands part-way through a prescaler second is also exercised, so a prescaler that is not cleared on reload would show up as a one-to-three-cycle shift in the expiry.

// File: rtl/reload_wdt_pkg.sv
package reload_wdt_pkg;

    localparam int TOV_W         = 10;
    localparam int BIT_LOCK      = 12;
    localparam int BIT_SURV      = 13;
    localparam int BIT_EN        = 14;
    localparam int BIT_FORCE     = 15;
    localparam int BIT_STS_PLAIN = 24;
    localparam int BIT_STS_SURV  = 25;
    localparam int BIT_RELOAD    = 31;

    typedef struct packed {
        logic [TOV_W-1:0] tov;
        logic             lock;
        logic             surv;
        logic             en;
        logic             force_on;
        logic             sts_plain;
        logic             sts_surv;
    } ctrl_t;

    function automatic logic [31:0] pack_ctrl(ctrl_t c);
        logic [31:0] w;
        w                = '0;
        w[TOV_W-1:0]     = c.tov;
        w[BIT_LOCK]      = c.lock;
        w[BIT_SURV]      = c.surv;
        w[BIT_EN]        = c.en;
        w[BIT_FORCE]     = c.force_on;
        w[BIT_STS_PLAIN] = c.sts_plain;
        w[BIT_STS_SURV]  = c.sts_surv;
        return w;
    endfunction

endpackage

// File: rtl/reload_wdt_prescaler.sv
module reload_wdt_prescaler #(
    parameter int TICK_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);

    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    generate
        if (TICK_CYCLES == 1) begin : g_direct
            // Every running cycle is a full second.
            assign tick = run;
        end else begin : g_count
            logic [PW-1:0] cnt_d, cnt_q;

            always_comb begin
                tick  = run && (cnt_q == LAST);
                cnt_d = cnt_q;
                if (clear) begin
                    cnt_d = '0;
                end else if (tick) begin
                    cnt_d = '0;
                end else if (run) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/reload_wdt_counter.sv
module reload_wdt_counter #(
    parameter int TOV_W        = 10,
    parameter int PULSE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             reload_go,
    input  logic [TOV_W-1:0] reload_tov,
    output logic             run,
    output logic             rst_req,
    output logic             expire_done
);

    localparam int SW  = TOV_W + 1;
    localparam int PCW = $clog2(PULSE_CYCLES + 1);
    localparam logic [PCW-1:0] PULSE_LOAD = PCW'(PULSE_CYCLES);
    localparam logic [SW-1:0]  ONE_SEC    = SW'(1);

    typedef struct packed {
        logic [SW-1:0]  secs;
        logic           armed;
        logic [PCW-1:0] pulse;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       expire;

    always_comb begin
        s_d    = s_q;
        run    = s_q.armed && en;
        expire = tick && (s_q.secs == ONE_SEC) && !reload_go;

        if (reload_go) begin
            s_d.secs  = {1'b0, reload_tov} + ONE_SEC;
            s_d.armed = 1'b1;
        end else begin
            if (tick) begin
                s_d.secs = s_q.secs - ONE_SEC;
            end
            if (expire || !en) begin
                s_d.armed = 1'b0;
            end
        end

        if (expire) begin
            s_d.pulse = PULSE_LOAD;
        end else if (s_q.pulse != '0) begin
            s_d.pulse = s_q.pulse - 1'b1;
        end
    end

    assign rst_req     = (s_q.pulse != '0);
    assign expire_done = (s_q.pulse == PCW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/reload_wdt_regs.sv
module reload_wdt_regs
    import reload_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             expire_done,
    output ctrl_t            ctrl,
    output logic             reload_go,
    output logic [TOV_W-1:0] reload_tov
);

    ctrl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (!s_q.lock) begin
                s_d.tov      = wr_data[TOV_W-1:0];
                s_d.surv     = wr_data[BIT_SURV];
                s_d.en       = wr_data[BIT_EN];
                s_d.force_on = wr_data[BIT_FORCE];
            end
            if (wr_data[BIT_LOCK]) begin
                s_d.lock = 1'b1;
            end
            if (wr_data[BIT_STS_SURV]) begin
                s_d.sts_surv = 1'b0;
            end
            if (wr_data[BIT_STS_PLAIN]) begin
                s_d.sts_plain = 1'b0;
            end
        end
        // Setting a flag wins over a clear in the same cycle.
        if (expire_done) begin
            if (s_q.surv) begin
                s_d.sts_surv = 1'b1;
            end else begin
                s_d.sts_plain = 1'b1;
            end
        end
        reload_go  = wr_en && wr_data[BIT_RELOAD] && s_d.en;
        reload_tov = s_d.tov;
    end

    assign ctrl = s_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/reload_wdt.sv
module reload_wdt
    import reload_wdt_pkg::*;
#(
    parameter int TICK_CYCLES  = 50_000_000,
    parameter int PULSE_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        rst_req
);

    ctrl_t            ctrl;
    logic             reload_go;
    logic [TOV_W-1:0] reload_tov;
    logic             expire_done;
    logic             run;
    logic             tick;

    reload_wdt_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .expire_done (expire_done),
        .ctrl        (ctrl),
        .reload_go   (reload_go),
        .reload_tov  (reload_tov)
    );

    reload_wdt_prescaler #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (reload_go),
        .run   (run),
        .tick  (tick)
    );

    reload_wdt_counter #(
        .TOV_W        (TOV_W),
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctrl.en),
        .tick        (tick),
        .reload_go   (reload_go),
        .reload_tov  (reload_tov),
        .run         (run),
        .rst_req     (rst_req),
        .expire_done (expire_done)
    );

    assign rd_data = pack_ctrl(ctrl);

endmodule

// File: rtl/reload_wdt_chk.sv
module reload_wdt_chk #(
    parameter int PULSE_CYCLES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] rd_data,
    input logic        rst_req
);

    int hi_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len_q <= 0;
        end else if (rst_req) begin
            hi_len_q <= hi_len_q + 1;
        end else begin
            hi_len_q <= 0;
        end
    end

    // R8: the request lasts exactly the configured number of cycles
    assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (hi_len_q == PULSE_CYCLES));

    // R8: a status flag is set by the time the request drops
    assert_status_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (rd_data[25] || rd_data[24]));

    // R10: lock cannot be cleared by a write
    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[12] |=> rd_data[12]);

    // R10: locked configuration does not move
    assert_locked_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[12] |=> ($stable(rd_data[15:13]) && $stable(rd_data[9:0])));

    // R7: no request starts while enable is clear
    assert_no_req_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[14] |=> !$rose(rst_req));

endmodule

bind reload_wdt reload_wdt_chk #(
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_data (rd_data),
    .rst_req (rst_req)
);

// File: tb/reload_wdt_tb.sv
module reload_wdt_tb;

    localparam int T = 4;
    localparam int P = 3;

    localparam logic [31:0] RLD  = 32'h8000_0000;
    localparam logic [31:0] S25  = 32'h0200_0000;
    localparam logic [31:0] S24  = 32'h0100_0000;
    localparam logic [31:0] FRC  = 32'h0000_8000;
    localparam logic [31:0] EN   = 32'h0000_4000;
    localparam logic [31:0] SURV = 32'h0000_2000;
    localparam logic [31:0] LOCK = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    reload_wdt #(
        .TICK_CYCLES  (T),
        .PULSE_CYCLES (P)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .rst_req (rst_req)
    );

    // Behavioural reference model
    int m_tov, m_surv, m_en, m_frc, m_lock, m_s25, m_s24;
    int m_secs, m_presc, m_armed, m_pulse;

    always @(posedge clk) begin
        int n_tov, n_surv, n_en, n_frc, n_lock, n_s25, n_s24;
        int n_secs, n_presc, n_armed, n_pulse;
        bit run, tick, reload, expire;
        if (!rst_n) begin
            m_tov = 0; m_surv = 0; m_en = 0; m_frc = 0; m_lock = 0;
            m_s25 = 0; m_s24 = 0; m_secs = 0; m_presc = 0; m_armed = 0; m_pulse = 0;
        end else begin
            n_tov = m_tov; n_surv = m_surv; n_en = m_en; n_frc = m_frc;
            n_lock = m_lock; n_s25 = m_s25; n_s24 = m_s24;
            if (wr_en) begin
                if (m_lock == 0) begin
                    n_tov  = int'(wr_data[9:0]);
                    n_surv = int'(wr_data[13]);
                    n_en   = int'(wr_data[14]);
                    n_frc  = int'(wr_data[15]);
                end
                if (wr_data[12]) n_lock = 1;
                if (wr_data[25]) n_s25 = 0;
                if (wr_data[24]) n_s24 = 0;
            end
            if (m_pulse == 1) begin
                if (m_surv != 0) n_s25 = 1; else n_s24 = 1;
            end
            run    = (m_armed != 0) && (m_en != 0);
            tick   = run && (m_presc == T - 1);
            reload = wr_en && wr_data[31] && (n_en != 0);
            expire = tick && (m_secs == 1) && !reload;
            n_presc = reload ? 0 : (tick ? 0 : (run ? m_presc + 1 : m_presc));
            n_secs  = reload ? n_tov + 1 : (tick ? m_secs - 1 : m_secs);
            n_armed = reload ? 1 : ((expire || m_en == 0) ? 0 : m_armed);
            n_pulse = expire ? P : ((m_pulse > 0) ? m_pulse - 1 : 0);
            m_tov = n_tov; m_surv = n_surv; m_en = n_en; m_frc = n_frc; m_lock = n_lock;
            m_s25 = n_s25; m_s24 = n_s24; m_secs = n_secs; m_presc = n_presc;
            m_armed = n_armed; m_pulse = n_pulse;
        end
    end

    function automatic logic [31:0] model_word();
        logic [31:0] w;
        w = 32'(m_tov);
        if (m_lock != 0) w = w | LOCK;
        if (m_surv != 0) w = w | SURV;
        if (m_en   != 0) w = w | EN;
        if (m_frc  != 0) w = w | FRC;
        if (m_s24  != 0) w = w | S24;
        if (m_s25  != 0) w = w | S25;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison with the model (R2 layout, R3 timing)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 model word", rd_data, model_word());
            check("R3 model request", {31'b0, rst_req}, {31'b0, m_pulse != 0});
        end
    end

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(input int n, output bit seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req) seen = 1;
        end
    endtask

    task automatic until_req(output int n);
        n = 0;
        while (!rst_req && n < 6000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (rst_req && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        bit seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);
        rst_n = 1'b1;

        // R3 / R8 basic expiry, 70 s
        wr(RLD | EN | 32'd69);
        until_req(n);
        check("R3 expiry cycles", n, 70 * T);
        pulse_len(n);
        check("R8 pulse length", n, P);
        check("R8 R2 status without survivability", rd_data, EN | 32'd69 | S24);
        idle(400, seen);
        check("R8 halted after expiry", {31'b0, seen}, 32'h0);

        // R9: W1C
        wr(EN | 32'd69);
        check("R9 zero leaves status", rd_data, EN | 32'd69 | S24);
        wr(EN | 32'd69 | S24);
        check("R9 one clears status", rd_data, EN | 32'd69);

        // R4: reload ignored while disabled
        wr(RLD | 32'd100);
        check("R4 R2 reload reads zero", rd_data, 32'd100);
        idle(500, seen);
        check("R4 no request", {31'b0, seen}, 32'h0);

        // R5: everything in one write, new timeout used
        wr(RLD | EN | FRC | SURV | 32'd71);
        until_req(n);
        check("R5 expiry cycles", n, 72 * T);
        pulse_len(n);
        check("R8 status with survivability", rd_data, EN | FRC | SURV | 32'd71 | S25);
        wr(EN | FRC | SURV | 32'd71 | S25);
        check("R9 clear survivability status", rd_data, EN | FRC | SURV | 32'd71);

        // R6: reload mid-second restarts everything
        wr(RLD | EN | 32'd69);
        idle(150, seen);
        wr(RLD | EN | 32'd69);
        until_req(n);
        check("R6 expiry from last reload", n, 70 * T);
        pulse_len(n);
        wr(EN | 32'd69 | S24);

        // R7: disable halts; re-enable without reload stays quiet
        wr(RLD | EN | 32'd69);
        idle(100, seen);
        wr(32'd69);
        idle(400, seen);
        check("R7 no request after disable", {31'b0, seen}, 32'h0);
        wr(EN | 32'd69);
        idle(400, seen);
        check("R7 no request after re-enable", {31'b0, seen}, 32'h0);
        check("R7 word", rd_data, EN | 32'd69);

        // R10 / R11: lock
        wr(RLD | LOCK | EN | 32'd69);
        idle(50, seen);
        wr(SURV | 32'd200);
        check("R10 config ignored under lock", rd_data, LOCK | EN | 32'd69);
        idle(100, seen);
        wr(RLD);
        until_req(n);
        check("R10 reload works under lock", n, 70 * T);
        pulse_len(n);
        check("R11 lock and status survive request", rd_data, LOCK | EN | 32'd69 | S24);
        wr(S24);
        check("R10 status clear under lock", rd_data, LOCK | EN | 32'd69);

        finish_up();
    end

endmodule